// File: doc/BRIEF.md
# Reference Loss and Tuning Limit Monitor

This block supervises a timing module's frequency reference and its oscillator steering. A nominal 8 kHz reference clock arrives asynchronously. The block brings it into the system clock domain and detects one edge per reference period. It then times the gaps between edges. When the reference stops, `ref_lost` rises after a fixed silent interval. The flag clears again only after the reference has produced a run of correctly spaced periods. This difference between the set and clear rules stops a reference that is flickering or off-frequency from toggling the flag.

A second path watches the digital tuning word that steers the oscillator. A guard band covers one tenth of the full code range at the bottom end and one tenth at the top end. While the word sits in either band, `tune_limit` is high, which warns that the loop is close to running out of steering range. The word must stay on one side of a threshold for a configurable number of cycles before the flag follows it. A brief excursion has no effect.

Both flags go to the mode controller, which combines them into its alarm. All delays are parameters counted in system clock cycles. A system clock of 125 MHz gives the default values: a loss delay of 3 ms, a good-period window of 104 us to 150 us around the 125 us reference period, and a tuning filter of 1 ms.

Top module: `ref_tune_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it rises, `ref_lost` is 1 and `tune_limit` is 0.
- R2: Each active (rising) edge of `ref_in` counts as a reference edge. This holds for a high pulse and for a low pulse, each at least 4 system clock cycles wide. An active edge reaches the period logic through a synchroniser of `SYNC_STAGES` flops plus one edge-detect flop.
- R3: `ref_lost` rises exactly `LOSS_CYC` cycles after the last edge detected inside the block. Measured from the active edge on `ref_in`, that is `LOSS_CYC` plus 2 to 4 cycles. `ref_lost` does not rise earlier.
- R4: While `ref_lost` is 1, it clears only after `RELEASE_PERIODS` (default 2) consecutive intervals between detected edges, each of `GOOD_MIN_CYC` to `GOOD_MAX_CYC` cycles inclusive. The first edge after a silence or after reset never counts as a good interval.
- R5: While `ref_lost` is 1, an interval shorter than `GOOD_MIN_CYC` or longer than `GOOD_MAX_CYC` restarts the count of good intervals, and `ref_lost` stays 1.
- R6: While `ref_lost` is 0 and edges keep arriving less than `LOSS_CYC` cycles apart, `ref_lost` stays 0, even when the intervals fall outside the good-period window.
- R7: The guard thresholds are LO = floor((2^TUNE_W - 1)/10) and HI = (2^TUNE_W - 1) - LO. Both comparisons are inclusive, and the word is in the limit zone when it is at most LO or at least HI. For the default 12-bit word, LO = 409 and HI = 3686.
- R8: Suppose `tune_word` is applied before clock edge 0 and held, and the zone it selects differs from `tune_limit`. Then `tune_limit` takes the new value at clock edge `TUNE_FILT_CYC` and not before.
- R9: A `tune_word` excursion into the other zone that lasts `TUNE_FILT_CYC-1` cycles or fewer leaves `tune_limit` unchanged.
- R10: A reference that stops while held high asserts `ref_lost` with the same timing as one that stops while held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference clock, nominally 8 kHz |
| tune_word | input | TUNE_W | Oscillator tuning code, unsigned |
| ref_lost | output | 1 | Loss-of-reference flag |
| tune_limit | output | 1 | Tuning word inside a guard band at either end of its range |

## Verification
The assertions assume that `TUNE_FILT_CYC` is at least 2, that `LOSS_CYC` exceeds `GOOD_MAX_CYC`, and that each level on `ref_in` lasts at least a few system clock cycles, so that each real edge gives exactly one detected edge. The stimulus drives every reference transition on a falling clock edge and makes each pulse 32 ns wide, which is four clock periods. The tuning word changes only on falling edges and holds between changes. The bench scales the delay parameters down so that the loss delay, each good and bad interval, and each filter window fit in a few hundred cycles. The bench builds its interval patterns, long, short and alternating, around those scaled limits.

// File: rtl/ref_mon_pkg.sv
package ref_mon_pkg;

    // Position of a tuning code relative to the guard bands
    typedef enum logic [1:0] {
        ZONE_MID  = 2'd0,
        ZONE_LOW  = 2'd1,
        ZONE_HIGH = 2'd2
    } tune_zone_e;

    // Width of the low guard band for a word of w bits: a tenth of full scale
    function automatic longint guard_span(input int w);
        longint full;
        full = (longint'(1) << w) - 1;
        return full / 10;
    endfunction

    // Full-scale code for a word of w bits
    function automatic longint full_code(input int w);
        return (longint'(1) << w) - 1;
    endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
    parameter int SYNC_STAGES = 2,
    parameter bit EDGE_RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    // One extra flop beyond the synchroniser holds the previous level
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;
    logic            edge_d, edge_q;
    logic            lvl_new, lvl_old;

    assign lvl_new = sh_q[SYNC_STAGES-1];
    assign lvl_old = sh_q[SYNC_STAGES];

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], ref_i};
    end

    generate
        if (EDGE_RISING) begin : g_rise
            always_comb edge_d = lvl_new & ~lvl_old;
        end else begin : g_fall
            always_comb edge_d = ~lvl_new & lvl_old;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            edge_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            edge_q <= edge_d;
        end
    end

    assign edge_o = edge_q;

endmodule

// File: rtl/ref_loss_det.sv
module ref_loss_det #(
    parameter int LOSS_CYC        = 375000,
    parameter int GOOD_MIN_CYC    = 13000,
    parameter int GOOD_MAX_CYC    = 18750,
    parameter int RELEASE_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic lost_o
);
    localparam int GAP_W  = $clog2(LOSS_CYC + 1);
    localparam int GOOD_W = $clog2(RELEASE_PERIODS + 1);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(LOSS_CYC);

    typedef struct packed {
        logic [GAP_W-1:0]  gap;   // cycles since last detected edge, saturating
        logic [GOOD_W-1:0] good;  // consecutive in-window intervals while lost
        logic              lost;
    } loss_st_t;

    loss_st_t st_d, st_q;
    int       interval;
    logic     in_win;

    always_comb begin
        interval = int'(st_q.gap) + 1;
        in_win   = (interval >= GOOD_MIN_CYC) && (interval <= GOOD_MAX_CYC);
    end

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.gap = '0;
            if (st_q.lost) begin
                if (in_win) begin
                    if (int'(st_q.good) + 1 >= RELEASE_PERIODS) begin
                        st_d.lost = 1'b0;
                        st_d.good = '0;
                    end else begin
                        st_d.good = st_q.good + 1'b1;
                    end
                end else begin
                    st_d.good = '0;
                end
            end else begin
                st_d.good = '0;
            end
        end else begin
            if (st_q.gap != GAP_SAT) begin
                st_d.gap = st_q.gap + 1'b1;
            end
            if (int'(st_q.gap) + 1 >= LOSS_CYC) begin
                st_d.lost = 1'b1;
                st_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gap  <= GAP_SAT;
            st_q.good <= '0;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost_o = st_q.lost;

endmodule

// File: rtl/tune_limit_det.sv
module tune_limit_det
    import ref_mon_pkg::*;
#(
    parameter int TUNE_W        = 12,
    parameter int TUNE_FILT_CYC = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TUNE_W-1:0] tune_i,
    output logic              raw_o,
    output logic              flag_o
);
    localparam int CNT_W = $clog2(TUNE_FILT_CYC + 1);
    localparam logic [TUNE_W-1:0] LO_TH = TUNE_W'(guard_span(TUNE_W));
    localparam logic [TUNE_W-1:0] HI_TH = TUNE_W'(full_code(TUNE_W) - guard_span(TUNE_W));
    localparam logic [TUNE_W-1:0] MID_CODE = TUNE_W'(longint'(1) << (TUNE_W - 1));

    typedef struct packed {
        logic [TUNE_W-1:0] word;  // registered tuning code
        logic [CNT_W-1:0]  cnt;   // cycles the zone has disagreed with the flag
        logic              flag;
    } tune_st_t;

    tune_st_t   st_d, st_q;
    tune_zone_e zone;
    logic       raw;

    always_comb begin
        if (st_q.word <= LO_TH) begin
            zone = ZONE_LOW;
        end else if (st_q.word >= HI_TH) begin
            zone = ZONE_HIGH;
        end else begin
            zone = ZONE_MID;
        end
        raw = (zone != ZONE_MID);
    end

    always_comb begin
        st_d      = st_q;
        st_d.word = tune_i;
        if (raw == st_q.flag) begin
            st_d.cnt = '0;
        end else if (int'(st_q.cnt) + 1 >= TUNE_FILT_CYC) begin
            st_d.flag = raw;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= MID_CODE;
            st_q.cnt  <= '0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = raw;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/ref_tune_monitor.sv
module ref_tune_monitor #(
    parameter int TUNE_W          = 12,
    parameter int SYNC_STAGES     = 2,
    parameter int LOSS_CYC        = 375000,
    parameter int GOOD_MIN_CYC    = 13000,
    parameter int GOOD_MAX_CYC    = 18750,
    parameter int RELEASE_PERIODS = 2,
    parameter int TUNE_FILT_CYC   = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [TUNE_W-1:0] tune_word,
    output logic              ref_lost,
    output logic              tune_limit
);
    logic ref_edge;
    logic tune_raw;

    ref_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .EDGE_RISING (1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_in),
        .edge_o (ref_edge)
    );

    ref_loss_det #(
        .LOSS_CYC        (LOSS_CYC),
        .GOOD_MIN_CYC    (GOOD_MIN_CYC),
        .GOOD_MAX_CYC    (GOOD_MAX_CYC),
        .RELEASE_PERIODS (RELEASE_PERIODS)
    ) u_loss (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (ref_edge),
        .lost_o (ref_lost)
    );

    tune_limit_det #(
        .TUNE_W        (TUNE_W),
        .TUNE_FILT_CYC (TUNE_FILT_CYC)
    ) u_tune (
        .clk    (clk),
        .rst_n  (rst_n),
        .tune_i (tune_word),
        .raw_o  (tune_raw),
        .flag_o (tune_limit)
    );

endmodule

// File: rtl/ref_tune_checker.sv
module ref_tune_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_edge,
    input logic ref_lost,
    input logic tune_raw,
    input logic tune_limit
);
    // R3 / R10: loss rises only after a cycle with no detected edge
    assert_lost_rise_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost) |-> !$past(ref_edge));

    // R4: loss clears only on the cycle after a detected edge
    assert_lost_fall_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_lost) |-> $past(ref_edge));

    // R7: flag rises only when the registered word lay in a guard band
    assert_limit_rise_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tune_limit) |-> $past(tune_raw));

    // R7: flag falls only when the registered word lay between the bands
    assert_limit_fall_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tune_limit) |-> !$past(tune_raw));

    // R9: a flag change needs the zone held for at least two cycles
    assert_limit_filtered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_limit != $past(tune_limit)) |-> ($past(tune_raw, 2) == $past(tune_raw)));

endmodule

bind ref_tune_monitor ref_tune_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_edge   (ref_edge),
    .ref_lost   (ref_lost),
    .tune_raw   (tune_raw),
    .tune_limit (tune_limit)
);

// File: tb/sim_ref_tune_monitor.sv
`timescale 1ns/1ps
module sim_ref_tune_monitor;
    localparam int W    = 12;
    localparam int LOSS = 200;
    localparam int GMIN = 30;
    localparam int GMAX = 50;
    localparam int FILT = 16;
    localparam int TCK  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_in = 1'b0;
    logic [W-1:0] tune_word = 12'd2048;
    logic         ref_lost, tune_limit;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(TCK/2) clk = ~clk;

    ref_tune_monitor #(
        .TUNE_W          (W),
        .SYNC_STAGES     (2),
        .LOSS_CYC        (LOSS),
        .GOOD_MIN_CYC    (GMIN),
        .GOOD_MAX_CYC    (GMAX),
        .RELEASE_PERIODS (2),
        .TUNE_FILT_CYC   (FILT)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .tune_word  (tune_word),
        .ref_lost   (ref_lost),
        .tune_limit (tune_limit)
    );

    typedef struct packed {
        logic [W-1:0] word;
        logic         lim;
    } vec_t;

    // R7 boundary codes, 12-bit: LO = 409, HI = 3686
    localparam vec_t VEC [8] = '{
        '{word: 12'd2048, lim: 1'b0},
        '{word: 12'd0,    lim: 1'b1},
        '{word: 12'd409,  lim: 1'b1},
        '{word: 12'd410,  lim: 1'b0},
        '{word: 12'd3685, lim: 1'b0},
        '{word: 12'd3686, lim: 1'b1},
        '{word: 12'd4095, lim: 1'b1},
        '{word: 12'd1000, lim: 1'b0}
    };

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        #(n * TCK);
    endtask

    // Pulses high for 32 ns, period per cycles; rising edge at each start
    task automatic hi_pulses(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b1;
            #32;
            ref_in = 1'b0;
            #(per * TCK - 32);
        end
    endtask

    // Idle high, dips low for 32 ns; rising edge at the end of each dip
    task automatic lo_pulses(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b0;
            #32;
            ref_in = 1'b1;
            #(per * TCK - 32);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(ref_lost, 1'b1, "R1 lost during reset");
        chk(tune_limit, 1'b0, "R1 limit during reset");
        rst_n = 1'b1;
        cyc(2);
        chk(ref_lost, 1'b1, "R1 lost after reset");
        chk(tune_limit, 1'b0, "R1 limit after reset");

        // Vector walk over the guard thresholds
        foreach (VEC[i]) begin
            tune_word = VEC[i].word;
            cyc(FILT + 4);
            chk(tune_limit, VEC[i].lim, $sformatf("R7 word %0d", VEC[i].word));
        end

        // R8 exact filter latency, mid to limit
        tune_word = 12'd4095;
        cyc(FILT - 1);
        chk(tune_limit, 1'b0, "R8 not yet changed");
        cyc(4);
        chk(tune_limit, 1'b1, "R8 changed after filter");

        // R9 short dip to mid is ignored
        tune_word = 12'd2048;
        cyc(FILT / 2);
        tune_word = 12'd4095;
        cyc(FILT + 4);
        chk(tune_limit, 1'b1, "R9 short mid excursion");
        tune_word = 12'd2048;
        cyc(FILT + 4);
        chk(tune_limit, 1'b0, "R8 limit to mid");
        tune_word = 12'd0;
        cyc(FILT - 1);
        tune_word = 12'd2048;
        cyc(FILT + 4);
        chk(tune_limit, 1'b0, "R9 excursion of FILT-1 cycles");

        // R4 release after two good intervals, first edge does not count
        hi_pulses(2, 40);
        chk(ref_lost, 1'b1, "R4 one good interval only");
        hi_pulses(1, 40);
        chk(ref_lost, 1'b0, "R4 released after two");

        // R6 steady reference, and off-window intervals while clear
        hi_pulses(10, 40);
        chk(ref_lost, 1'b0, "R6 steady reference");
        hi_pulses(3, 120);
        chk(ref_lost, 1'b0, "R6 long but under loss delay");
        hi_pulses(3, 20);
        chk(ref_lost, 1'b0, "R6 short intervals while clear");

        // R3 loss timing: last rising edge was 20 cycles ago
        cyc(LOSS - 4 - 20);
        chk(ref_lost, 1'b0, "R3 not before delay");
        cyc(12);
        chk(ref_lost, 1'b1, "R3 asserted after delay");

        // R5 intervals outside the window do not release
        hi_pulses(4, 70);
        chk(ref_lost, 1'b1, "R5 long intervals");
        hi_pulses(4, 20);
        chk(ref_lost, 1'b1, "R5 short intervals");
        hi_pulses(1, 40);   // interval 20: bad
        hi_pulses(1, 70);   // interval 40: good
        hi_pulses(1, 40);   // interval 70: bad, count restarts
        hi_pulses(1, 40);   // interval 40: good
        chk(ref_lost, 1'b1, "R5 alternating keeps loss");
        hi_pulses(1, 40);   // interval 40: second consecutive good
        chk(ref_lost, 1'b0, "R4 release after consecutive pair");

        // R10 stuck high: rising edge now, then held
        ref_in = 1'b1;
        cyc(LOSS - 4);
        chk(ref_lost, 1'b0, "R10 stuck high before delay");
        cyc(12);
        chk(ref_lost, 1'b1, "R10 stuck high asserts");

        // R2 narrow low pulses recover the reference
        lo_pulses(2, 40);
        chk(ref_lost, 1'b1, "R2 low pulses, one good interval");
        lo_pulses(1, 40);
        chk(ref_lost, 1'b0, "R2 low pulses detected");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule